// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block picks, every cycle, at most one hardware thread to feed a shared instruction-extraction stage. A thread can be picked only when it is active, its line queue holds at least one line, and its downstream buffer can take one more slot. The block only decides; the queues, the reservation and the extraction all live around it.

The decision is combinational from the flag inputs and two small registers: a priority reference holding the last winner, and a free-running 8-bit LFSR. A two-bit policy input picks how the candidate threads are ordered. Single mode looks at thread 0 only. Rotating mode scans from the thread after the last winner. Shuffled mode scans from a start point taken from the LFSR. In every mode the first eligible thread in scan order wins, and the winner becomes the new priority reference.

Top module: `fetch_thread_pick`

## Requirements
- R1: `pickValid` is high only when the thread named by `pickId` has `threadActive`, `lineReady` and `slotFree` all high in that same cycle.
- R2: If no thread in the considered set is eligible, `pickValid` is low and `pickId` is 0. In rotating and shuffled modes, any eligible thread makes `pickValid` high in the same cycle.
- R3: With `policy` = 0 or 3 (single mode), only thread 0 is considered: `pickValid` equals thread 0's eligibility, `pickId` is 0, and the flags of every other thread have no effect on the output.
- R4: With `policy` = 1 (rotating mode), threads are scanned from (priority reference + 1) mod THREADS upward, wrapping to 0. The first eligible thread is output in the same cycle.
- R5: The priority reference resets to 0. At each clock edge where `pickValid` is high, in any mode, it takes the value of `pickId`. Otherwise it holds.
- R6: With `policy` = 2 (shuffled mode), threads are scanned upward from (LFSR value mod THREADS), wrapping to 0. The first eligible thread wins.
- R7: The LFSR resets to 0xA5 and advances on every clock edge after reset. It shifts toward bit 7, and the XOR of old bits 7, 5, 4 and 3 enters at bit 0. It is never zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| policy | input | 2 | 0/3 single, 1 rotating, 2 shuffled |
| threadActive | input | THREADS | Per-thread active flag |
| lineReady | input | THREADS | Per-thread queue holds a line |
| slotFree | input | THREADS | Per-thread downstream buffer can accept a slot |
| pickValid | output | 1 | A thread is picked this cycle |
| pickId | output | $clog2(THREADS) | Picked thread, 0 when none |

## Verification
The assertions take the flags and the policy to be known values that are steady around each rising edge. They also take the policy to be allowed to change on any cycle, since the priority reference must track winners in every mode. The stimulus changes every input only on the falling edge and draws the flags at several densities, so that no-eligible cycles, single-eligible cycles and fully eligible cycles all occur. It also switches the policy both in long runs and on every cycle, so that reference hand-over between modes is exercised.

// File: rtl/ftp_pkg.sv
package ftp_pkg;
  typedef enum logic [1:0] {
    POL_SOLO    = 2'd0,
    POL_ROTATE  = 2'd1,
    POL_SHUFFLE = 2'd2,
    POL_SOLO_B  = 2'd3
  } policy_e;

  localparam int START_CAP_W = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic                   soloOnly;
    logic [START_CAP_W-1:0] startIdx;
  } scanCtl_t;
endpackage

// File: rtl/ftp_ctrl.sv
module ftp_ctrl
  import ftp_pkg::*;
#(
  parameter int THREADS = 4,
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] TAP_MASK = 8'hB8,
  parameter logic [LFSR_W-1:0] SEED = 8'hA5,
  localparam int IDW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        policy,
  input  logic              pickValid,
  input  logic [IDW-1:0]    pickId,
  output scanCtl_t          scan,
  output logic [IDW-1:0]    prioRef,
  output logic [LFSR_W-1:0] lfsrState
);
  logic [IDW-1:0]    prioQ;
  logic [LFSR_W-1:0] lfsrQ;
  logic [IDW-1:0]    rotStart;
  logic [IDW-1:0]    shufStart;
  policy_e           pol;

  assign pol = policy_e'(policy);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prioQ <= '0;
      lfsrQ <= SEED;
    end else begin
      if (pickValid) prioQ <= pickId;
      lfsrQ <= {lfsrQ[LFSR_W-2:0], ^(lfsrQ & TAP_MASK)};
    end
  end

  assign rotStart  = (prioQ == IDW'(THREADS - 1)) ? '0 : prioQ + 1'b1;
  assign shufStart = IDW'(int'(lfsrQ) % THREADS);

  always_comb begin
    scan = '0;
    unique case (pol)
      POL_ROTATE:  scan.startIdx = START_CAP_W'(rotStart);
      POL_SHUFFLE: scan.startIdx = START_CAP_W'(shufStart);
      default:     scan.soloOnly = 1'b1;
    endcase
  end

  assign prioRef   = prioQ;
  assign lfsrState = lfsrQ;
endmodule

// File: rtl/ftp_path.sv
module ftp_path
  import ftp_pkg::*;
#(
  parameter int THREADS = 4,
  localparam int IDW = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic [THREADS-1:0] threadActive,
  input  logic [THREADS-1:0] lineReady,
  input  logic [THREADS-1:0] slotFree,
  input  scanCtl_t           scan,
  output logic               pickValid,
  output logic [IDW-1:0]     pickId
);
  logic [THREADS-1:0] eligible;
  logic [THREADS-1:0] cand;

  for (genvar t = 0; t < THREADS; t++) begin : g_elig
    assign eligible[t] = threadActive[t] & lineReady[t] & slotFree[t];
    if (t == 0) begin : g_head
      assign cand[t] = eligible[t];
    end else begin : g_rest
      assign cand[t] = eligible[t] & ~scan.soloOnly;
    end
  end

  always_comb begin
    pickValid = 1'b0;
    pickId    = '0;
    for (int k = 0; k < THREADS; k++) begin
      int idx;
      idx = int'(scan.startIdx) + k;
      if (idx >= THREADS) idx = idx - THREADS;
      if (!pickValid && cand[idx]) begin
        pickValid = 1'b1;
        pickId    = IDW'(idx);
      end
    end
  end
endmodule

// File: rtl/fetch_thread_pick.sv
module fetch_thread_pick
  import ftp_pkg::*;
#(
  parameter int THREADS = 4,
  localparam int IDW = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int LFSR_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         policy,
  input  logic [THREADS-1:0] threadActive,
  input  logic [THREADS-1:0] lineReady,
  input  logic [THREADS-1:0] slotFree,
  output logic               pickValid,
  output logic [IDW-1:0]     pickId
);
  scanCtl_t          scan;
  logic [IDW-1:0]    prioRef;
  logic [LFSR_W-1:0] lfsrState;

  ftp_ctrl #(.THREADS(THREADS), .LFSR_W(LFSR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .policy(policy),
    .pickValid(pickValid), .pickId(pickId),
    .scan(scan), .prioRef(prioRef), .lfsrState(lfsrState)
  );

  ftp_path #(.THREADS(THREADS)) u_path (
    .threadActive(threadActive), .lineReady(lineReady), .slotFree(slotFree),
    .scan(scan), .pickValid(pickValid), .pickId(pickId)
  );
endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
  parameter int THREADS = 4,
  localparam int IDW = (THREADS > 1) ? $clog2(THREADS) : 1,
  localparam int LW = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         policy,
  input logic [THREADS-1:0] threadActive,
  input logic [THREADS-1:0] lineReady,
  input logic [THREADS-1:0] slotFree,
  input logic               pickValid,
  input logic [IDW-1:0]     pickId,
  input logic [IDW-1:0]     prioRef,
  input logic [LW-1:0]      lfsrState
);
  AST_PICK_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    pickValid |-> (threadActive[pickId] && lineReady[pickId] && slotFree[pickId])); // R1
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !pickValid |-> (pickId == '0)); // R2
  AST_WORK_CONSERVE: assert property (@(posedge clk) disable iff (!rstN)
    ((policy == 2'd1 || policy == 2'd2) && |(threadActive & lineReady & slotFree)) |-> pickValid); // R2
  AST_SOLO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((policy == 2'd0 || policy == 2'd3) && pickValid) |-> (pickId == '0)); // R3
  AST_PRIO_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    pickValid |=> (prioRef == $past(pickId))); // R5
  AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !pickValid |=> $stable(prioRef)); // R5
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    lfsrState != '0); // R7
  AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (lfsrState[LW-1:1] == $past(lfsrState[LW-2:0]))); // R7
endmodule

bind fetch_thread_pick ftp_checker #(.THREADS(THREADS)) chk (
  .clk(clk), .rstN(rstN), .policy(policy),
  .threadActive(threadActive), .lineReady(lineReady), .slotFree(slotFree),
  .pickValid(pickValid), .pickId(pickId),
  .prioRef(prioRef), .lfsrState(lfsrState)
);

// File: tb/fetch_thread_pick_test.sv
`timescale 1ns/1ps
module fetch_thread_pick_test;
  localparam int T = 4;
  localparam int IDW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] policy = 2'd1;
  logic [T-1:0] threadActive = '1, lineReady = '1, slotFree = '1;
  logic pickValid;
  logic [IDW-1:0] pickId;

  int errors = 0, checks = 0;
  bit done = 0;
  int mPrio = 0;
  int mLfsr = 8'hA5;

  always #10 clk = ~clk;

  fetch_thread_pick #(.THREADS(T)) uut (
    .clk(clk), .rstN(rstN), .policy(policy),
    .threadActive(threadActive), .lineReady(lineReady), .slotFree(slotFree),
    .pickValid(pickValid), .pickId(pickId)
  );

  function automatic logic [T-1:0] flags(int pct);
    logic [T-1:0] f;
    for (int i = 0; i < T; i++) f[i] = (($urandom % 100) < pct);
    return f;
  endfunction

  task automatic cycle();
    bit expV = 0;
    int expId = 0;
    int start;
    logic [T-1:0] elig;
    string tag;
    #1;
    elig = threadActive & lineReady & slotFree;
    if (policy == 2'd0 || policy == 2'd3) begin
      expV = elig[0];
    end else begin
      start = (policy == 2'd1) ? (mPrio + 1) % T : mLfsr % T;
      for (int k = 0; k < T; k++)
        if (!expV && elig[(start + k) % T]) begin expV = 1; expId = (start + k) % T; end
    end
    if (!rstN) tag = "R5/R7 reset state";
    else if (!expV) tag = "R1/R2";
    else if (policy == 2'd1) tag = "R4/R5";
    else if (policy == 2'd2) tag = "R6/R7";
    else tag = "R3";
    checks++;
    if (pickValid !== expV || int'(pickId) != expId) begin
      errors++;
      $display("FAIL %s: actual valid=%0d id=%0d expected valid=%0d id=%0d",
               tag, pickValid, pickId, expV, expId);
    end
    @(posedge clk);
    if (rstN) begin
      if (expV) mPrio = expId;
      mLfsr = ((mLfsr << 1) & 255) | (((mLfsr >> 7) ^ (mLfsr >> 5) ^ (mLfsr >> 4) ^ (mLfsr >> 3)) & 1);
    end
    @(negedge clk);
  endtask

  task automatic runPhase(int n, int pol, int pct);
    for (int i = 0; i < n; i++) begin
      policy = (pol < 0) ? 2'($urandom % 4) : 2'(pol);
      threadActive = flags(pct);
      lineReady = flags(pct);
      slotFree = flags(pct);
      cycle();
    end
  endtask

  initial begin
    @(negedge clk);
    cycle();                       // reset state, rotating: expect thread 1
    policy = 2'd2; cycle();        // reset state, shuffled: 0xA5 mod 4 = 1
    rstN = 1'b1;
    policy = 2'd1;
    for (int i = 0; i < 2 * T; i++) cycle();    // R4 full rotation, all eligible
    for (int t = 0; t < T; t++) begin           // R1 one flag missing each
      threadActive = '1; lineReady = '1; slotFree = '1;
      threadActive[t] = 1'b0; cycle();
      threadActive = '1; lineReady[t] = 1'b0; cycle();
      lineReady = '1; slotFree[t] = 1'b0; cycle();
      slotFree = '1;
    end
    policy = 2'd0;                              // R3 others ignored
    threadActive = 4'b1110; cycle();
    threadActive = 4'b0001; lineReady = 4'b0001; slotFree = 4'b0001; cycle();
    threadActive = '0; lineReady = '0; slotFree = '0;
    policy = 2'd1; cycle();                     // R2 none eligible
    runPhase(300, 0, 80);
    runPhase(400, 1, 75);
    runPhase(400, 2, 75);
    runPhase(100, 3, 80);
    runPhase(600, -1, 70);
    runPhase(400, -1, 35);
    runPhase(200, 2, 100);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule